// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block keeps one private cache coherent with its peers on a shared, atomic snooping bus. It holds a tag and a coherence state for every line of a direct-mapped cache. Each state is one of Invalid, Shared or Modified. Processor reads and writes are resolved locally when the state allows it. Otherwise the block raises a bus request carrying the matching transaction. When the grant arrives, the transaction completes in that same cycle and the line takes its new state.

In cycles where another cache owns the bus, the block watches that cache's transaction on the snoop input. A snooped read of a line held Modified makes this cache supply the data, flag a writeback to memory, and fall back to Shared. A snooped exclusive read or upgrade removes any local copy. Data movement is outside this block. The block only signals who supplies the data and when memory must absorb a writeback. All addresses are line addresses, with the low bits selecting the line.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and no output is asserted until a request or a snoop arrives.
- R2: A processor read of a line that is not present raises bus_req with bus_cmd 0 (shared read) and the requested address. When bus_grant arrives, cpu_done rises in that cycle with cpu_hit 0 and cpu_state 1 (Shared).
- R3: A snooped shared read (snoop_cmd 0) of a line held Shared leaves snoop_supply and snoop_wb low, and the line stays Shared, so a later processor read hits.
- R4: A processor write to a line held Shared requests bus_cmd 2 (upgrade, no data). On grant it completes with cpu_state 2 (Modified).
- R5: A processor write to a line that is not present requests bus_cmd 1 (exclusive read). On grant it completes with cpu_state 2.
- R6: A processor read or write of a line held Modified completes in the same cycle with cpu_hit 1, cpu_state 2 and no bus request.
- R7: A snooped shared read of a line held Modified asserts both snoop_supply and snoop_wb in that cycle and moves the line to Shared, so a later local write asks for an upgrade.
- R8: A snooped exclusive read (1) or upgrade (2) of a present line invalidates it. For a Modified line, an exclusive read also asserts snoop_supply without snoop_wb.
- R9: Snoops take precedence: cpu_done stays low in any cycle with snoop_valid high.
- R10: A miss whose index holds a Modified line of another tag first requests bus_cmd 3 (writeback) at the victim's address without completing the request, then issues the fill. A Shared victim is dropped and the fill is requested directly.
- R11: A snoop whose tag differs from the line stored at its index has no effect on that line and asserts neither snoop output.
- R12: If a pending upgrade loses its Shared copy to a snooped invalidation before its grant, the request turns into an exclusive read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Processor request present, held until cpu_done |
| cpu_write | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | AW | Line address of the request |
| cpu_done | output | 1 | Request completes in this cycle |
| cpu_hit | output | 1 | Completed without a bus transaction |
| cpu_state | output | 2 | Line state after completion (1 Shared, 2 Modified) |
| bus_req | output | 1 | Bus transaction wanted |
| bus_grant | input | 1 | Bus granted; the transaction completes this cycle |
| bus_cmd | output | 2 | 0 shared read, 1 exclusive read, 2 upgrade, 3 writeback |
| bus_addr | output | AW | Line address of the transaction |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_cmd | input | 2 | Command of the snooped transaction, same encoding |
| snoop_addr | input | AW | Line address of the snooped transaction |
| snoop_supply | output | 1 | This cache supplies the data; memory stays silent |
| snoop_wb | output | 1 | Memory must take the supplied data as a writeback |

## Verification
The assertions take for granted that the arbiter never grants this cache in a cycle that carries a snoop, and that it grants only while bus_req is high. They also assume the processor keeps its request steady until cpu_done. The bench drives grants only after it has seen bus_req, and it raises snoop_valid only in cycles where bus_grant is low. It holds cpu_valid, cpu_write and cpu_addr unchanged across each request, including the cycles where a snoop interrupts a pending request.

// File: rtl/msi_pkg.sv
package msi_pkg;
   typedef enum logic [1:0] {
      ST_I = 2'd0,
      ST_S = 2'd1,
      ST_M = 2'd2
   } line_st_t;

   typedef enum logic [1:0] {
      CMD_RD  = 2'd0,
      CMD_RDX = 2'd1,
      CMD_UPG = 2'd2,
      CMD_WB  = 2'd3
   } bus_cmd_t;
endpackage

// File: rtl/msi_line_array.sv
module msi_line_array
   import msi_pkg::*;
#(
   parameter int NLINES = 8,
   parameter int TAGW   = 9,
   localparam int IDXW  = $clog2(NLINES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IDXW-1:0] cpu_idx,
   output logic [TAGW-1:0] cpu_tag_o,
   output line_st_t        cpu_st_o,
   input  logic [IDXW-1:0] snp_idx,
   output logic [TAGW-1:0] snp_tag_o,
   output line_st_t        snp_st_o,
   input  logic            wr_en,
   input  logic [IDXW-1:0] wr_idx,
   input  logic [TAGW-1:0] wr_tag,
   input  line_st_t        wr_st
);
   logic [TAGW-1:0] tag_q [NLINES];
   line_st_t        st_q  [NLINES];

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q[i]  <= ST_I;
            tag_q[i] <= '0;
         end else if (wr_en && wr_idx == IDXW'(i)) begin
            st_q[i]  <= wr_st;
            tag_q[i] <= wr_tag;
         end
      end

      // R1: a line only ever holds one of the three legal states
      a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
         st_q[i] != 2'b11);
   end

   assign cpu_tag_o = tag_q[cpu_idx];
   assign cpu_st_o  = st_q[cpu_idx];
   assign snp_tag_o = tag_q[snp_idx];
   assign snp_st_o  = st_q[snp_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
   import msi_pkg::*;
#(
   parameter int TAGW = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            snoop_valid,
   input  bus_cmd_t        snoop_cmd,
   input  logic [TAGW-1:0] snoop_tag,
   input  logic [TAGW-1:0] line_tag,
   input  line_st_t        line_st,
   output logic            supply,
   output logic            writeback,
   output logic            upd_en,
   output line_st_t        upd_st
);
   logic present, owned, is_rd, is_inval;

   assign present  = snoop_valid && (line_tag == snoop_tag) && (line_st != ST_I);
   assign owned    = present && (line_st == ST_M);
   assign is_rd    = (snoop_cmd == CMD_RD);
   assign is_inval = (snoop_cmd == CMD_RDX) || (snoop_cmd == CMD_UPG);

   assign supply    = owned && (is_rd || snoop_cmd == CMD_RDX);
   assign writeback = owned && is_rd;

   always_comb begin
      upd_en = 1'b0;
      upd_st = line_st;
      if (present && is_inval) begin
         upd_en = 1'b1;
         upd_st = ST_I;
      end else if (owned && is_rd) begin
         upd_en = 1'b1;
         upd_st = ST_S;
      end
   end

   // R7: a writeback is only flagged when this cache is supplying the data
   a_r7_wb_with_supply: assert property (@(posedge clk) disable iff (!rst_n)
      writeback |-> supply);
   // R8: nothing is supplied outside a snoop cycle
   a_r8_supply_in_snoop: assert property (@(posedge clk) disable iff (!rst_n)
      supply |-> snoop_valid);
endmodule

// File: rtl/msi_cpu_ctrl.sv
module msi_cpu_ctrl
   import msi_pkg::*;
#(
   parameter int AW   = 12,
   parameter int IDXW = 3,
   localparam int TAGW = AW - IDXW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cpu_valid,
   input  logic            cpu_write,
   input  logic [AW-1:0]   cpu_addr,
   input  logic [TAGW-1:0] line_tag,
   input  line_st_t        line_st,
   input  logic            snoop_valid,
   input  logic            bus_grant,
   output logic            done,
   output logic            hit,
   output line_st_t        resp_st,
   output logic            bus_req,
   output bus_cmd_t        bus_cmd,
   output logic [AW-1:0]   bus_addr,
   output logic            upd_en,
   output logic [TAGW-1:0] upd_tag,
   output line_st_t        upd_st
);
   logic [TAGW-1:0] req_tag;
   logic [IDXW-1:0] req_idx;
   logic            present, victim_m, granted;

   assign req_tag  = cpu_addr[AW-1:IDXW];
   assign req_idx  = cpu_addr[IDXW-1:0];
   assign present  = (line_tag == req_tag) && (line_st != ST_I);
   assign victim_m = (line_tag != req_tag) && (line_st == ST_M);
   assign hit      = cpu_valid && present && (!cpu_write || line_st == ST_M);

   always_comb begin
      if (victim_m)       bus_cmd = CMD_WB;
      else if (!cpu_write) bus_cmd = CMD_RD;
      else if (present)   bus_cmd = CMD_UPG;
      else                bus_cmd = CMD_RDX;
   end

   assign bus_req  = cpu_valid && !hit;
   assign bus_addr = victim_m ? {line_tag, req_idx} : cpu_addr;
   assign granted  = bus_req && bus_grant && !snoop_valid;
   assign done     = cpu_valid && !snoop_valid && (hit || (granted && bus_cmd != CMD_WB));
   assign resp_st  = hit ? line_st : ((bus_cmd == CMD_RD) ? ST_S : ST_M);

   assign upd_en  = granted;
   assign upd_tag = victim_m ? line_tag : req_tag;
   always_comb begin
      unique case (bus_cmd)
         CMD_WB:  upd_st = ST_I;
         CMD_RD:  upd_st = ST_S;
         default: upd_st = ST_M;
      endcase
   end

   // R5: every completed write leaves the line Modified
   a_r5_write_ends_m: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cpu_write) |-> (resp_st == ST_M));
   // R2: a read that needed the bus ends Shared
   a_r2_read_fill_s: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cpu_write && !hit) |-> (resp_st == ST_S));
   // R10: a writeback grant never completes the processor request
   a_r10_wb_not_done: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_grant && bus_req && bus_cmd == CMD_WB) |-> !done);
   // R6: a hit never asks for the bus
   a_r6_hit_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> !bus_req);
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
   import msi_pkg::*;
#(
   parameter int AW     = 12,
   parameter int NLINES = 8,
   localparam int IDXW  = $clog2(NLINES),
   localparam int TAGW  = AW - IDXW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_valid,
   input  logic          cpu_write,
   input  logic [AW-1:0] cpu_addr,
   output logic          cpu_done,
   output logic          cpu_hit,
   output logic [1:0]    cpu_state,
   output logic          bus_req,
   input  logic          bus_grant,
   output logic [1:0]    bus_cmd,
   output logic [AW-1:0] bus_addr,
   input  logic          snoop_valid,
   input  logic [1:0]    snoop_cmd,
   input  logic [AW-1:0] snoop_addr,
   output logic          snoop_supply,
   output logic          snoop_wb
);
   if (NLINES < 2 || (1 << IDXW) != NLINES) begin : g_bad_lines
      $error("NLINES must be a power of two of at least 2");
   end
   if (TAGW < 1) begin : g_bad_aw
      $error("AW must exceed the index width");
   end

   logic [TAGW-1:0] c_tag, s_tag, c_upd_tag;
   line_st_t        c_st, s_st, c_upd_st, s_upd_st, resp_st;
   logic            c_upd_en, s_upd_en, wr_en;
   logic [IDXW-1:0] wr_idx;
   logic [TAGW-1:0] wr_tag;
   line_st_t        wr_st;
   bus_cmd_t        cmd_q;

   msi_line_array #(.NLINES(NLINES), .TAGW(TAGW)) u_array (
      .clk(clk), .rst_n(rst_n),
      .cpu_idx(cpu_addr[IDXW-1:0]), .cpu_tag_o(c_tag), .cpu_st_o(c_st),
      .snp_idx(snoop_addr[IDXW-1:0]), .snp_tag_o(s_tag), .snp_st_o(s_st),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_st(wr_st)
   );

   msi_snoop_unit #(.TAGW(TAGW)) u_snoop (
      .clk(clk), .rst_n(rst_n),
      .snoop_valid(snoop_valid), .snoop_cmd(bus_cmd_t'(snoop_cmd)),
      .snoop_tag(snoop_addr[AW-1:IDXW]), .line_tag(s_tag), .line_st(s_st),
      .supply(snoop_supply), .writeback(snoop_wb),
      .upd_en(s_upd_en), .upd_st(s_upd_st)
   );

   msi_cpu_ctrl #(.AW(AW), .IDXW(IDXW)) u_cpu (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
      .line_tag(c_tag), .line_st(c_st),
      .snoop_valid(snoop_valid), .bus_grant(bus_grant),
      .done(cpu_done), .hit(cpu_hit), .resp_st(resp_st),
      .bus_req(bus_req), .bus_cmd(cmd_q), .bus_addr(bus_addr),
      .upd_en(c_upd_en), .upd_tag(c_upd_tag), .upd_st(c_upd_st)
   );

   // Snoop updates win; the processor side is stalled in snoop cycles
   assign wr_en  = s_upd_en || c_upd_en;
   assign wr_idx = s_upd_en ? snoop_addr[IDXW-1:0] : cpu_addr[IDXW-1:0];
   assign wr_tag = s_upd_en ? s_tag : c_upd_tag;
   assign wr_st  = s_upd_en ? s_upd_st : c_upd_st;

   assign bus_cmd   = cmd_q;
   assign cpu_state = resp_st;

   // R9: the arbiter keeps grants and snoops in separate cycles
   a_r9_atomic_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !(snoop_valid && bus_grant));
   // R9: no processor completion while a snoop is being served
   a_r9_snoop_first: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_valid |-> !cpu_done);
   // R4: an upgrade is only requested while the line is held Shared
   a_r4_upg_from_s: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && cmd_q == CMD_UPG) |-> (c_st == ST_S));
   // R10: a writeback is only requested for a Modified victim
   a_r10_wb_from_m: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && cmd_q == CMD_WB) |-> (c_st == ST_M));
endmodule

// File: tb/msi_snoop_ctrl_bench.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_bench;
   localparam int AW = 12;
   localparam logic [AW-1:0] A = 12'h010;  // index 0, tag 2
   localparam logic [AW-1:0] B = 12'h018;  // index 0, tag 3
   localparam logic [AW-1:0] C = 12'h021;  // index 1, tag 4

   logic clk = 1'b0, rst_n = 1'b0;
   logic cpu_valid = 0, cpu_write = 0, bus_grant = 0, snoop_valid = 0;
   logic [AW-1:0] cpu_addr = '0, snoop_addr = '0;
   logic [1:0] snoop_cmd = '0;
   logic cpu_done, cpu_hit, bus_req, snoop_supply, snoop_wb;
   logic [1:0] cpu_state, bus_cmd;
   logic [AW-1:0] bus_addr;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   msi_snoop_ctrl #(.AW(AW), .NLINES(8)) u_msi_snoop_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
      .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_state(cpu_state),
      .bus_req(bus_req), .bus_grant(bus_grant), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
      .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
      .snoop_supply(snoop_supply), .snoop_wb(snoop_wb)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cpu_op(input logic w, input logic [AW-1:0] addr, input logic exp_hit,
                         input logic [1:0] exp_cmd, input logic [1:0] exp_st, input string req);
      @(negedge clk);
      cpu_valid = 1; cpu_write = w; cpu_addr = addr;
      #1;
      if (exp_hit) begin
         chk(req, "done", cpu_done, 1);
         chk(req, "hit", cpu_hit, 1);
         chk(req, "bus_req", bus_req, 0);
      end else begin
         chk(req, "bus_req", bus_req, 1);
         chk(req, "bus_cmd", bus_cmd, exp_cmd);
         chk(req, "bus_addr", bus_addr, addr);
         chk(req, "early done", cpu_done, 0);
         bus_grant = 1;
         #1;
         chk(req, "done", cpu_done, 1);
         chk(req, "hit", cpu_hit, 0);
      end
      chk(req, "state", cpu_state, exp_st);
      @(posedge clk); #1;
      cpu_valid = 0; bus_grant = 0;
   endtask

   task automatic snoop_op(input logic [1:0] cmd, input logic [AW-1:0] addr,
                           input logic exp_sup, input logic exp_wb, input string req);
      @(negedge clk);
      snoop_valid = 1; snoop_cmd = cmd; snoop_addr = addr;
      #1;
      chk(req, "supply", snoop_supply, exp_sup);
      chk(req, "wb", snoop_wb, exp_wb);
      @(posedge clk); #1;
      snoop_valid = 0;
   endtask

   // {req[24:21], snoop[20], wr[19], cmd[18:17], addr[16:5], hit[4], st[3:2], sup[1], wb[0]}
   localparam int NV = 18;
   localparam logic [24:0] VEC [NV] = '{
      {4'd2,  1'b0, 1'b0, 2'd0, A, 1'b0, 2'd1, 1'b0, 1'b0},  // R1/R2 first read misses
      {4'd3,  1'b0, 1'b0, 2'd0, A, 1'b1, 2'd1, 1'b0, 1'b0},  // R3 read hit on Shared
      {4'd3,  1'b1, 1'b0, 2'd0, A, 1'b0, 2'd0, 1'b0, 1'b0},  // R3 snooped read of Shared
      {4'd3,  1'b0, 1'b0, 2'd0, A, 1'b1, 2'd1, 1'b0, 1'b0},  // R3 still Shared
      {4'd4,  1'b0, 1'b1, 2'd2, A, 1'b0, 2'd2, 1'b0, 1'b0},  // R4 upgrade
      {4'd6,  1'b0, 1'b0, 2'd0, A, 1'b1, 2'd2, 1'b0, 1'b0},  // R6 read hit on Modified
      {4'd6,  1'b0, 1'b1, 2'd0, A, 1'b1, 2'd2, 1'b0, 1'b0},  // R6 write hit on Modified
      {4'd7,  1'b1, 1'b0, 2'd0, A, 1'b0, 2'd0, 1'b1, 1'b1},  // R7 owner supplies, writeback
      {4'd7,  1'b0, 1'b1, 2'd2, A, 1'b0, 2'd2, 1'b0, 1'b0},  // R7 now Shared: upgrade
      {4'd8,  1'b1, 1'b0, 2'd1, A, 1'b0, 2'd0, 1'b1, 1'b0},  // R8 exclusive read takes Modified
      {4'd8,  1'b0, 1'b0, 2'd0, A, 1'b0, 2'd1, 1'b0, 1'b0},  // R8 invalidated: read misses
      {4'd8,  1'b1, 1'b0, 2'd2, A, 1'b0, 2'd0, 1'b0, 1'b0},  // R8 snooped upgrade on Shared
      {4'd5,  1'b0, 1'b1, 2'd1, A, 1'b0, 2'd2, 1'b0, 1'b0},  // R5 write miss
      {4'd11, 1'b1, 1'b0, 2'd0, B, 1'b0, 2'd0, 1'b0, 1'b0},  // R11 other tag, same index
      {4'd11, 1'b0, 1'b0, 2'd0, A, 1'b1, 2'd2, 1'b0, 1'b0},  // R11 line untouched
      {4'd2,  1'b0, 1'b0, 2'd0, C, 1'b0, 2'd1, 1'b0, 1'b0},  // R2 second index
      {4'd8,  1'b1, 1'b0, 2'd1, C, 1'b0, 2'd0, 1'b0, 1'b0},  // R8 exclusive read on Shared
      {4'd5,  1'b0, 1'b1, 2'd1, C, 1'b0, 2'd2, 1'b0, 1'b0}   // R5 write miss after loss
   };

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1: idle outputs after reset
      chk("R1", "bus_req", bus_req, 0);
      chk("R1", "done", cpu_done, 0);
      chk("R1", "supply", snoop_supply, 0);

      foreach (VEC[i]) begin
         string req;
         logic [24:0] v;
         v = VEC[i];
         req = $sformatf("R%0d", v[24:21]);
         if (v[20]) snoop_op(v[18:17], v[16:5], v[1], v[0], req);
         else       cpu_op(v[19], v[16:5], v[4], v[18:17], v[3:2], req);
      end

      // R10: Modified victim A is written back before B is filled
      @(negedge clk);
      cpu_valid = 1; cpu_write = 0; cpu_addr = B;
      #1;
      chk("R10", "bus_cmd", bus_cmd, 3);
      chk("R10", "bus_addr", bus_addr, A);
      bus_grant = 1; #1;
      chk("R10", "done on wb", cpu_done, 0);
      @(negedge clk);
      chk("R10", "fill cmd", bus_cmd, 0);
      chk("R10", "fill addr", bus_addr, B);
      #1;
      chk("R10", "done", cpu_done, 1);
      @(posedge clk); #1;
      cpu_valid = 0; bus_grant = 0;
      // R10: Shared victim B is dropped silently
      cpu_op(1'b0, A, 1'b0, 2'd0, 2'd1, "R10");

      // R12: pending upgrade loses its copy and becomes an exclusive read
      @(negedge clk);
      cpu_valid = 1; cpu_write = 1; cpu_addr = A;
      #1;
      chk("R12", "bus_cmd", bus_cmd, 2);
      @(negedge clk);
      snoop_valid = 1; snoop_cmd = 2'd1; snoop_addr = A;
      #1;
      chk("R9", "done during snoop", cpu_done, 0);
      @(negedge clk);
      snoop_valid = 0;
      #1;
      chk("R12", "bus_cmd", bus_cmd, 1);
      bus_grant = 1; #1;
      chk("R12", "done", cpu_done, 1);
      chk("R12", "state", cpu_state, 2);
      @(posedge clk); #1;
      cpu_valid = 0; bus_grant = 0;

      // R9: a hit waits while an unrelated snoop is served
      @(negedge clk);
      cpu_valid = 1; cpu_write = 0; cpu_addr = A;
      snoop_valid = 1; snoop_cmd = 2'd0; snoop_addr = C;
      #1;
      chk("R9", "done", cpu_done, 0);
      chk("R7", "supply", snoop_supply, 1);
      @(negedge clk);
      snoop_valid = 0;
      #1;
      chk("R9", "done after", cpu_done, 1);
      chk("R9", "hit", cpu_hit, 1);
      @(posedge clk); #1;
      cpu_valid = 0;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule